// File: doc/BRIEF.md
# Majority Threshold Road Control

This block is the control cell of one pattern ("road") in a pattern-recognition associative memory used for track finding. Each road watches a fixed number of detector layers. Per-layer match pulses arrive from the layer comparators, and the block holds each pulse in a sticky flag until the end of the event. The block counts how many layers have matched and reports the result as a saturating thermometer code. With four layers this code is 111 for a full match, 011 when one layer is missing, 001 when two are missing, and 000 when three or more are missing.

A user-programmed threshold, written in the same code domain, decides whether the road raises its flag. A per-road disable bit can silence a road. An event-rearm pulse clears the sticky flags. The flag and the code are combinational functions of the held flags, the threshold and the disable bit. They therefore follow those inputs within the same cycle.

Top module: `road_ctrl`

## Requirements
- R1: A high bit on `layer_hit[k]` at a rising clock edge sets the held flag of layer k. The flag stays set on later edges while `rearm` and `rst` are low, whatever `layer_hit` does.
- R2: With all four layers held, `maj_code` is 3'b111.
- R3: With exactly one of the four layers not held, `maj_code` is 3'b011.
- R4: With exactly two of the four layers not held, `maj_code` is 3'b001.
- R5: With three or four layers not held, `maj_code` is 3'b000.
- R6: For a nonzero `thresh`, an enabled road raises `road_flag` exactly when every bit set in `thresh` is also set in `maj_code`. Threshold bit i has the same weight as code bit i.
- R7: With `thresh` = 3'b000, an enabled road raises `road_flag` only while at least one layer is held.
- R8: While `road_off` is high, `road_flag` is 0. `maj_code` still reports the held layers.
- R9: `rearm` high at a rising edge clears every held flag. Hits presented at that same edge are dropped, so after the edge `maj_code` is 000 and `road_flag` is 0.
- R10: `rst` high at a rising edge (synchronous, active high) clears every held flag.
- R11: `road_flag` follows changes on `thresh` and `road_off` in the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| layer_hit | input | NUM_LAYERS | Per-layer match pulses from the layer comparators |
| rearm | input | 1 | End-of-event clear of the held layer flags |
| thresh | input | NUM_LAYERS-1 | Threshold in thermometer-code form |
| road_off | input | 1 | Disables the road flag of this road |
| maj_code | output | NUM_LAYERS-1 | Saturating thermometer code of the matched-layer count |
| road_flag | output | 1 | Road-match flag |

## Verification
The bench builds the block with the default NUM_LAYERS = 4, which gives the 3-bit code of the requirements. At this size every matched-layer count from zero to four, and every threshold pattern, can be reached with a handful of hit vectors. This includes thresholds that are not thermometer codes, such as 010 and 101. The directed part covers four things: layers that are accumulated over several cycles, a rearm that coincides with hits, a change of threshold or disable with no clock edge in between, and the empty-road case under the zero threshold.

// File: rtl/road_ctrl_pkg.sv
package road_ctrl_pkg;

    // Layer count of one road, used as the default of the blocks below
    localparam int DEF_LAYERS = 4;

    // Decision state of the threshold gate
    typedef enum logic [1:0] {
        GATE_OFF   = 2'd0,   // road disabled
        GATE_EMPTY = 2'd1,   // nothing held, zero threshold cannot fire
        GATE_SHORT = 2'd2,   // code does not cover threshold
        GATE_PASS  = 2'd3    // road fires
    } gate_state_t;

    // True when every bit of thr is also set in code (8-bit container)
    function automatic logic covers(input logic [7:0] code, input logic [7:0] thr);
        return (code & thr) == thr;
    endfunction

endpackage

// File: rtl/road_match_hold.sv
module road_match_hold #(
    parameter int NUM_LAYERS = road_ctrl_pkg::DEF_LAYERS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rearm,
    input  logic [NUM_LAYERS-1:0] layer_hit,
    output logic [NUM_LAYERS-1:0] held
);
    // Sticky per-layer flags; rearm has priority over incoming hits
    always_ff @(posedge clk) begin
        if (rst || rearm)
            held <= '0;
        else
            held <= held | layer_hit;
    end
endmodule

// File: rtl/road_majority_enc.sv
module road_majority_enc #(
    parameter int NUM_LAYERS = road_ctrl_pkg::DEF_LAYERS,
    localparam int CODE_W    = NUM_LAYERS - 1,
    localparam int CNT_W     = $clog2(NUM_LAYERS + 1)
) (
    input  logic [NUM_LAYERS-1:0] held,
    output logic [CODE_W-1:0]     code,
    output logic                  any_held
);
    logic [CNT_W-1:0] n_held;

    always_comb begin
        n_held = '0;
        for (int k = 0; k < NUM_LAYERS; k++)
            n_held = n_held + CNT_W'(held[k]);
    end

    // Code bit i set when at least i+2 layers are held: saturating thermometer
    for (genvar i = 0; i < CODE_W; i++) begin : g_therm
        assign code[i] = (n_held >= CNT_W'(i + 2));
    end

    assign any_held = |held;
endmodule

// File: rtl/road_thresh_gate.sv
module road_thresh_gate #(
    parameter int NUM_LAYERS = road_ctrl_pkg::DEF_LAYERS,
    localparam int CODE_W    = NUM_LAYERS - 1
) (
    input  logic [CODE_W-1:0] code,
    input  logic [CODE_W-1:0] thresh,
    input  logic              any_held,
    input  logic              road_off,
    output logic              road_flag
);
    import road_ctrl_pkg::*;

    gate_state_t state;

    always_comb begin
        if (road_off)
            state = GATE_OFF;
        else if (thresh == '0 && !any_held)
            state = GATE_EMPTY;
        else if (covers(8'(code), 8'(thresh)))
            state = GATE_PASS;
        else
            state = GATE_SHORT;
    end

    assign road_flag = (state == GATE_PASS);
endmodule

// File: rtl/road_ctrl.sv
module road_ctrl #(
    parameter int NUM_LAYERS = road_ctrl_pkg::DEF_LAYERS,
    localparam int CODE_W    = NUM_LAYERS - 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_LAYERS-1:0] layer_hit,
    input  logic                  rearm,
    input  logic [CODE_W-1:0]     thresh,
    input  logic                  road_off,
    output logic [CODE_W-1:0]     maj_code,
    output logic                  road_flag
);
    logic [NUM_LAYERS-1:0] layer_seen;
    logic                  any_seen;

    road_match_hold #(.NUM_LAYERS(NUM_LAYERS)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .rearm     (rearm),
        .layer_hit (layer_hit),
        .held      (layer_seen)
    );

    road_majority_enc #(.NUM_LAYERS(NUM_LAYERS)) u_enc (
        .held     (layer_seen),
        .code     (maj_code),
        .any_held (any_seen)
    );

    road_thresh_gate #(.NUM_LAYERS(NUM_LAYERS)) u_gate (
        .code      (maj_code),
        .thresh    (thresh),
        .any_held  (any_seen),
        .road_off  (road_off),
        .road_flag (road_flag)
    );
endmodule

// File: rtl/road_ctrl_chk.sv
module road_ctrl_chk #(
    parameter int NUM_LAYERS = 4,
    localparam int CODE_W    = NUM_LAYERS - 1
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  rearm,
    input logic [NUM_LAYERS-1:0] layer_hit,
    input logic [NUM_LAYERS-1:0] layer_seen,
    input logic [CODE_W-1:0]     thresh,
    input logic                  road_off,
    input logic [CODE_W-1:0]     maj_code,
    input logic                  road_flag
);
    // R1: held layers never drop without rearm
    assert_sticky_R1: assert property (@(posedge clk) disable iff (rst)
        !rearm |=> (($past(layer_seen) & ~layer_seen) == '0));

    // R1: a hit is held after its edge
    assert_hit_held_R1: assert property (@(posedge clk) disable iff (rst)
        (!rearm && layer_hit != '0) |=> ((layer_seen & $past(layer_hit)) == $past(layer_hit)));

    // R2-R5: the code is always a legal thermometer value
    assert_therm_legal_R5: assert property (@(posedge clk) disable iff (rst)
        ((maj_code + CODE_W'(1)) & maj_code) == '0);

    // R6: a raised flag implies the code covers the threshold
    assert_flag_covers_R6: assert property (@(posedge clk) disable iff (rst)
        road_flag |-> ((maj_code & thresh) == thresh));

    // R7: a zero threshold never fires on an empty road
    assert_empty_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (thresh == '0 && layer_seen == '0) |-> !road_flag);

    // R8: a disabled road stays quiet
    assert_off_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        road_off |-> !road_flag);

    // R9: rearm empties the road on the next cycle
    assert_rearm_clear_R9: assert property (@(posedge clk) disable iff (rst)
        rearm |=> (maj_code == '0 && layer_seen == '0));
endmodule

bind road_ctrl road_ctrl_chk #(.NUM_LAYERS(NUM_LAYERS)) u_road_ctrl_chk (
    .clk        (clk),
    .rst        (rst),
    .rearm      (rearm),
    .layer_hit  (layer_hit),
    .layer_seen (layer_seen),
    .thresh     (thresh),
    .road_off   (road_off),
    .maj_code   (maj_code),
    .road_flag  (road_flag)
);

// File: tb/test_road_ctrl.sv
module test_road_ctrl;
    localparam int NL = 4;
    localparam int CW = NL - 1;

    logic          clk = 1'b0;
    logic          rst;
    logic [NL-1:0] layer_hit;
    logic          rearm;
    logic [CW-1:0] thresh;
    logic          road_off;
    logic [CW-1:0] maj_code;
    logic          road_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    road_ctrl #(.NUM_LAYERS(NL)) i_road_ctrl (
        .clk       (clk),
        .rst       (rst),
        .layer_hit (layer_hit),
        .rearm     (rearm),
        .thresh    (thresh),
        .road_off  (road_off),
        .maj_code  (maj_code),
        .road_flag (road_flag)
    );

    // Vector: {hits[3:0], thresh[2:0], off, exp_code[2:0], exp_flag}
    localparam int NV = 13;
    localparam logic [11:0] VEC [NV] = '{
        {4'b1111, 3'b111, 1'b0, 3'b111, 1'b1},  // R2 full match
        {4'b1101, 3'b111, 1'b0, 3'b011, 1'b0},  // R3 R6 one missing vs full thr
        {4'b0111, 3'b011, 1'b0, 3'b011, 1'b1},  // R3 R6
        {4'b1010, 3'b001, 1'b0, 3'b001, 1'b1},  // R4 R6
        {4'b0011, 3'b011, 1'b0, 3'b001, 1'b0},  // R4 R6 short
        {4'b0100, 3'b001, 1'b0, 3'b000, 1'b0},  // R5 three missing
        {4'b0000, 3'b000, 1'b0, 3'b000, 1'b0},  // R5 R7 empty road, zero thr
        {4'b1000, 3'b000, 1'b0, 3'b000, 1'b1},  // R7 one layer, zero thr
        {4'b1111, 3'b111, 1'b1, 3'b111, 1'b0},  // R8 disabled full
        {4'b1110, 3'b000, 1'b1, 3'b011, 1'b0},  // R8 disabled, zero thr
        {4'b1001, 3'b010, 1'b0, 3'b001, 1'b0},  // R6 non-thermometer thr
        {4'b0110, 3'b101, 1'b0, 3'b001, 1'b0},  // R6 non-thermometer thr
        {4'b1111, 3'b101, 1'b0, 3'b111, 1'b1}   // R6 non-thermometer thr met
    };

    task automatic check(input string tag, input logic [CW:0] act, input logic [CW:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; layer_hit = '1; rearm = 1'b0; thresh = '0; road_off = 1'b0;
        repeat (3) step();
        layer_hit = '0;
        #1;
        check("R10 reset code", {1'b0, maj_code}, 4'b0000);
        check("R10 reset flag", {3'b000, road_flag}, 4'b0000);
        rst = 1'b0;
        step();

        // Table walk
        for (int v = 0; v < NV; v++) begin
            rearm = 1'b1; layer_hit = '0;
            step();
            rearm = 1'b0; layer_hit = VEC[v][11:8];
            step();
            layer_hit = '0; thresh = VEC[v][7:5]; road_off = VEC[v][4];
            #1;
            check($sformatf("R2-R8 vec%0d code", v), {1'b0, maj_code}, {1'b0, VEC[v][3:1]});
            check($sformatf("R6 R7 R8 vec%0d flag", v), {3'b000, road_flag}, {3'b000, VEC[v][0]});
        end

        // R1: accumulate across cycles
        road_off = 1'b0; thresh = 3'b111;
        rearm = 1'b1; step(); rearm = 1'b0;
        layer_hit = 4'b0001; step();
        layer_hit = 4'b0100; step();
        layer_hit = '0; #1;
        check("R1 two layers held", {1'b0, maj_code}, 4'b0001);
        layer_hit = 4'b1000; step();
        layer_hit = 4'b0010; step();
        layer_hit = '0; step(); step();
        check("R1 held over idle cycles", {1'b0, maj_code}, 4'b0111);
        check("R1 flag after accumulation", {3'b000, road_flag}, 4'b0001);

        // R11: combinational follow without an edge
        @(posedge clk); #3;
        thresh = 3'b000; road_off = 1'b1; #1;
        check("R11 disable same cycle", {3'b000, road_flag}, 4'b0000);
        road_off = 1'b0; #1;
        check("R11 enable same cycle", {3'b000, road_flag}, 4'b0001);
        @(negedge clk);

        // R9: rearm drops concurrent hits
        rearm = 1'b1; layer_hit = 4'b1111; thresh = 3'b000;
        step();
        rearm = 1'b0; layer_hit = '0; #1;
        check("R9 code after rearm", {1'b0, maj_code}, 4'b0000);
        check("R9 flag after rearm", {3'b000, road_flag}, 4'b0000);

        // R10: reset mid-event
        layer_hit = 4'b1111; step(); layer_hit = '0;
        rst = 1'b1; step(); rst = 1'b0; #1;
        check("R10 reset clears held layers", {1'b0, maj_code}, 4'b0000);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule